// File: doc/BRIEF.md
# Sinc-Pulse Quadrature Modulator

This block builds a digital intermediate-frequency sample stream from two data bit streams, one in-phase and one quadrature. A symbol pair is taken through a valid/ready handshake once every 16 output samples. Each bit becomes +1 or -1 and scales a 256-tap truncated sinc pulse spanning 16 symbol periods, so every output sample sums the overlapping tails of the last 16 symbols in each branch.

The carrier sits at a quarter of the sample rate. The in-phase branch is multiplied by a sine carrier and the quadrature branch by a cosine carrier. That product reduces to picking one branch sum per sample and possibly negating it, so no multipliers are needed. The mixed value is scaled down, saturated and offset to an unsigned 8-bit word for a DAC. A sample enable paces the whole datapath. If the source has no symbol ready when one is due, a zero symbol is inserted and an underflow pulse is raised.

Top module: `sinc_iq_mod`

## Requirements
- R1: After synchronous reset `dac_out` is 0x80 and `underflow` is 0. The symbol history holds only zero symbols, and the sample phase is 0.
- R2: The sample phase advances by one on each clock with `ce` high and wraps from 15 to 0. `in_ready` is high exactly when `ce` is high and the phase is 0.
- R3: A symbol pair is taken on a clock where `in_valid` and `in_ready` are both high. An input bit of 1 becomes +1 and a bit of 0 becomes -1.
- R4: When `in_ready` is high and `in_valid` is low, a zero symbol enters both branches, and `underflow` is 1 for the clock cycle that follows. Otherwise `underflow` is 0.
- R5: Tap n (n = 0..255) equals round(256·sin(πx)/(πx)) with x = (n−128)/16, and tap 128 is exactly 256.
- R6: For sample k (0..15) of the current symbol, each branch sum is Σ s[m]·tap[k+16m] over m = 0..15. Here m = 0 is the symbol taken at this symbol's phase 0, and higher m are older symbols.
- R7: The mixed value depends on k mod 4: 0 gives +Q, 1 gives +I, 2 gives −Q, 3 gives −I.
- R8: The mixed value is shifted right arithmetically by OUT_SHIFT (default 1), saturated to [−128, 127] and offset by +128. The result is registered into `dac_out` on the clock where `ce` is high at sample k.
- R9: While `ce` is low, `dac_out`, the phase and the symbol history hold.
- R10: A value beyond the signed 8-bit range shows as 0xFF (positive) or 0x00 (negative), never as a wrapped code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Sample enable, one output sample per high cycle |
| in_valid | input | 1 | Source has a symbol pair |
| in_ready | output | 1 | Symbol pair is taken this cycle |
| in_i | input | 1 | In-phase data bit |
| in_q | input | 1 | Quadrature data bit |
| dac_out | output | 8 | Offset-binary output sample |
| underflow | output | 1 | A zero symbol was inserted on the previous clock |

## Verification
A wrong phase count shows at once as `in_ready` on the wrong enable. It also moves the carrier sign pattern by a sample, which changes `dac_out` on the next enabled clock. A bad history shift or a wrong tap only shows as an amplitude error. It appears one enable after the affected symbol enters, and it keeps showing for the 16 symbol periods that the symbol's pulse spans. Runs of identical bits push the sum into saturation, and that exposes wrapped output codes within a symbol or two.

// File: rtl/sinc_iq_mod.sv
module sinc_iq_mod #(
  parameter int OUT_SHIFT = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_i,
  input  logic       in_q,
  output logic [7:0] dac_out,
  output logic       underflow
);
  localparam int SPS   = 16;
  localparam int NSYM  = 16;
  localparam int NTAP  = SPS * NSYM;
  localparam int TAP_W = 10;
  localparam int ACC_W = 16;

  function automatic int qsin(input int j);
    case (j)
      0: return 0;
      1: return 12785;
      2: return 25080;
      3: return 36410;
      4: return 46341;
      5: return 54491;
      6: return 60547;
      7: return 64277;
      default: return 65536;
    endcase
  endfunction

  function automatic int tap_f(input int n);
    int a, r, j, num, den, mag;
    bit neg;
    a = (n < NTAP / 2) ? (NTAP / 2 - n) : (n - NTAP / 2);
    if (a == 0) return 256;
    r = a % 32;
    neg = (r > 16);
    if (r <= 8)       j = r;
    else if (r <= 16) j = 16 - r;
    else if (r <= 24) j = r - 16;
    else              j = 32 - r;
    num = qsin(j) * 4096;
    den = 205887 * a;
    mag = (2 * num + den) / (2 * den);
    return neg ? -mag : mag;
  endfunction

  logic signed [TAP_W-1:0] taps [NTAP];

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam logic signed [TAP_W-1:0] TV = TAP_W'(tap_f(g));
    assign taps[g] = TV;
  end

  logic [3:0] phase;
  logic [1:0] hist_i [NSYM];
  logic [1:0] hist_q [NSYM];
  logic [1:0] eff_i  [NSYM];
  logic [1:0] eff_q  [NSYM];
  logic signed [ACC_W-1:0] sum_i, sum_q, mix, shifted;
  logic [7:0] sat;

  assign in_ready = ce && (phase == 4'd0);

  always_comb begin
    for (int m = 0; m < NSYM; m++) begin
      eff_i[m] = hist_i[m];
      eff_q[m] = hist_q[m];
    end
    if (phase == 4'd0) begin
      eff_i[0] = {in_valid, in_i};
      eff_q[0] = {in_valid, in_q};
      for (int m = 1; m < NSYM; m++) begin
        eff_i[m] = hist_i[m-1];
        eff_q[m] = hist_q[m-1];
      end
    end
  end

  always_comb begin
    logic signed [ACC_W-1:0] tv;
    sum_i = '0;
    sum_q = '0;
    for (int m = 0; m < NSYM; m++) begin
      tv = ACC_W'(taps[m * SPS + int'(phase)]);
      if (eff_i[m][1]) sum_i = eff_i[m][0] ? sum_i + tv : sum_i - tv;
      if (eff_q[m][1]) sum_q = eff_q[m][0] ? sum_q + tv : sum_q - tv;
    end
  end

  always_comb begin
    case (phase[1:0])
      2'd0:    mix = sum_q;
      2'd1:    mix = sum_i;
      2'd2:    mix = -sum_q;
      default: mix = -sum_i;
    endcase
  end

  assign shifted = mix >>> OUT_SHIFT;

  always_comb begin
    if (shifted > 16'sd127)       sat = 8'h7F;
    else if (shifted < -16'sd128) sat = 8'h80;
    else                          sat = shifted[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      dac_out   <= 8'h80;
      underflow <= 1'b0;
      for (int m = 0; m < NSYM; m++) begin
        hist_i[m] <= '0;
        hist_q[m] <= '0;
      end
    end else begin
      underflow <= in_ready && !in_valid;
      if (ce) begin
        phase   <= phase + 4'd1;
        dac_out <= sat ^ 8'h80;
        for (int m = 0; m < NSYM; m++) begin
          hist_i[m] <= eff_i[m];
          hist_q[m] <= eff_q[m];
        end
      end
    end
  end
endmodule

module sinc_iq_mod_chk (
  input logic       clk,
  input logic       rst,
  input logic       ce,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] dac_out,
  input logic       underflow
);
  logic [3:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (ce) cnt <= cnt + 4'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dac_out == 8'h80 && !underflow));

  // R2
  ready_slot_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (ce && cnt == 4'd0));

  // R2
  ready_due_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && cnt == 4'd0) |-> in_ready);

  // R4
  underflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |-> $past(in_ready && !in_valid));

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(dac_out));
endmodule

bind sinc_iq_mod sinc_iq_mod_chk u_chk (.*);

// File: tb/tb_sinc_iq_mod.sv
`timescale 1ns/1ps
module tb_sinc_iq_mod;
  logic clk = 0;
  logic rst = 1;
  logic ce = 0, in_valid = 0, in_i = 0, in_q = 0;
  logic in_ready, underflow;
  logic [7:0] dac_out;

  always #2 clk = ~clk;

  sinc_iq_mod dut (.clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid),
    .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .dac_out(dac_out),
    .underflow(underflow));

  int checks = 0, failures = 0;
  int tap [256];
  int hi [16], hq [16];
  int ph = 0;
  int exp_dac = 128;
  int exp_uf = 0;
  bit done = 0;

  function automatic int ref_tap(input int n);
    real x, r;
    if (n == 128) return 256;
    x = 3.14159265358979 * real'(n - 128) / 16.0;
    r = 256.0 * $sin(x) / x;
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  task automatic chk(input string req, input int act, input int expv, input int tol);
    int d;
    checks++;
    d = act - expv;
    if (d > tol || d < -tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int m = 0; m < 16; m++) begin hi[m] = 0; hq[m] = 0; end
    ph = 0; exp_dac = 128; exp_uf = 0;
  endtask

  task automatic step(input bit c, input bit v, input bit bi, input bit bq, input string tag);
    int si, sq, mx, sh;
    @(negedge clk);
    chk({tag, " dac_out"}, int'(dac_out), exp_dac, 1);
    chk("R4 underflow", int'(underflow), exp_uf, 0);
    ce = c; in_valid = v; in_i = bi; in_q = bq;
    #1;
    chk("R2 in_ready", int'(in_ready), (c && ph == 0) ? 1 : 0, 0);
    exp_uf = (c && ph == 0 && !v) ? 1 : 0;
    if (c) begin
      if (ph == 0) begin
        for (int m = 15; m > 0; m--) begin hi[m] = hi[m-1]; hq[m] = hq[m-1]; end
        hi[0] = v ? (bi ? 1 : -1) : 0;
        hq[0] = v ? (bq ? 1 : -1) : 0;
      end
      si = 0; sq = 0;
      for (int m = 0; m < 16; m++) begin
        si += hi[m] * tap[ph + 16 * m];
        sq += hq[m] * tap[ph + 16 * m];
      end
      case (ph % 4)
        0: mx = sq;
        1: mx = si;
        2: mx = -sq;
        default: mx = -si;
      endcase
      sh = mx >>> 1;
      if (sh > 127) sh = 127;
      if (sh < -128) sh = -128;
      exp_dac = sh + 128;
      ph = (ph + 1) % 16;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int n = 0; n < 256; n++) tap[n] = ref_tap(n);
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    chk("R1 dac_out", int'(dac_out), 128, 0);
    chk("R1 underflow", int'(underflow), 0, 0);
    // idle with no symbols: zero inserted, mid-scale output (R1 R4)
    for (int k = 0; k < 20; k++) step(1, 0, 0, 0, "R1 R4");
    // single isolated pulse then silence (R3 R5 R6 R7 R8)
    step(1, 1, 1, 0, "R3 R5 R6");
    for (int k = 0; k < 15; k++) step(1, 0, 0, 0, "R5 R6 R7");
    for (int k = 0; k < 16 * 17; k++) step(1, 0, 0, 0, "R6 R7 R8");
    // long run of ones: saturation high (R10)
    for (int k = 0; k < 16 * 20; k++) step(1, 1, 1, 1, "R10 R8");
    // long run of zeros: negative saturation (R10)
    for (int k = 0; k < 16 * 20; k++) step(1, 1, 0, 0, "R10 R3");
    // enable gaps hold state (R9)
    for (int k = 0; k < 200; k++) step(k % 3 == 0, 1, k[2], k[3], "R9");
    // mid-run reset
    @(negedge clk); rst = 1; ce = 1;
    @(negedge clk); rst = 0; ce = 0;
    model_reset();
    chk("R1 dac_out after reset", int'(dac_out), 128, 0);
    // random stimulus
    for (int k = 0; k < 6000; k++) begin
      bit c, v;
      c = ($urandom % 10) < 7;
      v = ($urandom % 10) < 8;
      step(c, v, $urandom % 2, $urandom % 2, "R6 R7 R8");
    end
    step(0, 0, 0, 0, "R8");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule